// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns digitised supply-health signals into the reset and protection controls of a supervised system. A main comparator says whether the supply is above its reset threshold. A watchdog delivers a one-cycle timeout pulse. The sampled level of the bidirectional active-low reset pin can carry a manual reset from a push button. From these the block drives two open-drain reset outputs, both expressed as drive enables, and a write-inhibit for an attached non-volatile memory. Reset appears at once when the supply drops. It is released only after a programmable number of clean clock cycles.

One internal sequencer state feeds both reset polarities. The block cannot see the active-low pin while it pulls that pin itself. For this reason a reset started by the pin alone leaves the pin undriven until the button is let go. After the delay the block also spends one probe cycle with the pin released and the high-side reset still active, to find out whether the button is still held. A second, auxiliary comparator passes through a consecutive-sample filter and drives an open-drain low-voltage flag.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst` is high and right after it, `rst_hi_en`, `rst_lo_pull` and `wr_inhibit` are 1. `rst_hi_en` returns to 0 in the cycle after the (RELEASE_CYCLES+1)th clock edge that follows the last `rst` edge, provided no reset cause is sampled in between.
- R2: Whenever `supply_ok` is 0 (supply below threshold), `rst_hi_en`, `rst_lo_pull` and `wr_inhibit` are 1 in that same cycle, with no register delay.
- R3: A clock edge that samples any reset cause keeps reset active. `rst_hi_en` falls only after RELEASE_CYCLES+2 consecutive edges with no cause: one hold cycle, RELEASE_CYCLES counting cycles and one probe cycle.
- R4: A reset cause that arrives during the release delay restarts the delay from zero.
- R5: `rst_lo_pull` is 1 during every counting cycle and in any cycle with `supply_ok` at 0. It is 0 in the probe cycle and in a hold cycle that the pin alone caused. It is never 1 while `rst_hi_en` is 0.
- R6: `mr_pin_n` at 0 while `rst_lo_pull` is 0 is a manual reset cause. The reset holds as long as the pin stays low, and the full delay runs after the pin returns high. A pin still held low in the probe cycle sends the block back to hold, and `rst_hi_en` does not drop.
- R7: A `wdt_expire` pulse of 1 is a reset cause. `rst_hi_en` is 1 from the next cycle onward, and the full delay follows.
- R8: `wr_inhibit` is 1 exactly when `rst_hi_en` is 1.
- R9: `aux_low_pull` changes only after AUX_FILTER_CYCLES consecutive edges that sample `aux_ok` opposite to the current flag. It then becomes the inverse of that sampled value: 1 when `aux_ok` is 0 (below threshold).
- R10: After `rst`, `aux_low_pull` is 1 until the filter has seen AUX_FILTER_CYCLES samples of `aux_ok` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | 1 = main supply above reset threshold |
| wdt_expire | input | 1 | One-cycle watchdog timeout pulse |
| mr_pin_n | input | 1 | Sampled level of the active-low reset pin |
| aux_ok | input | 1 | 1 = auxiliary supply above its threshold |
| rst_hi_en | output | 1 | Drive enable of the active-high reset output |
| rst_lo_pull | output | 1 | 1 = pull the active-low reset pin low |
| wr_inhibit | output | 1 | 1 = memory writes blocked |
| aux_low_pull | output | 1 | 1 = pull the auxiliary low-voltage flag low |

## Verification
The bench builds the block with RELEASE_CYCLES = 12 and AUX_FILTER_CYCLES = 4, in place of a 200 ms count. With these values a full release delay, a restart halfway through it, and a button held across the probe cycle all fit within a few dozen cycles. The short filter makes it practical to drive auxiliary pulses both just shorter and just longer than the filter length. The pin is modelled as wired-AND with the block's own pull, so the block's read-back behaviour is exercised as it would be on a board.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_PROBE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic supply_low;
        logic wdt;
        logic manual;
    } cause_t;

    typedef struct packed {
        seq_state_e st;
        logic       by_pin;
    } seq_view_t;

    function automatic logic cause_any(cause_t c);
        return c.supply_low | c.wdt | c.manual;
    endfunction

    function automatic logic cause_pin_only(cause_t c);
        return c.manual & ~c.supply_low & ~c.wdt;
    endfunction

endpackage

// File: rtl/supv_release_timer.sv
module supv_release_timer #(
    parameter int unsigned DELAY = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic enable,
    output logic done
);
    localparam int unsigned W = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [W-1:0] LAST = W'(DELAY - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (enable && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/supv_seq.sv
module supv_seq
    import supv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cause_t    cause,
    input  logic      timer_done,
    output seq_view_t view
);
    seq_view_t nxt;

    always_comb begin
        nxt = view;
        if (cause_any(cause)) begin
            nxt.st     = ST_HOLD;
            nxt.by_pin = cause_pin_only(cause);
        end else begin
            unique case (view.st)
                ST_RUN:   nxt.st = ST_RUN;
                ST_HOLD:  nxt.st = ST_COUNT;
                ST_COUNT: nxt.st = timer_done ? ST_PROBE : ST_COUNT;
                ST_PROBE: nxt.st = ST_RUN;
                default:  nxt.st = ST_COUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            view.st     <= ST_COUNT;
            view.by_pin <= 1'b0;
        end else begin
            view <= nxt;
        end
    end
endmodule

// File: rtl/supv_aux_filter.sv
module supv_aux_filter #(
    parameter int unsigned FILT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_ok,
    output logic filt_ok
);
    generate
        if (FILT <= 1) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) filt_ok <= 1'b0;
                else     filt_ok <= raw_ok;
            end
        end else begin : g_count
            localparam int unsigned W = $clog2(FILT + 1);
            localparam logic [W-1:0] LAST = W'(FILT - 1);
            logic [W-1:0] run;
            always_ff @(posedge clk) begin
                if (rst) begin
                    filt_ok <= 1'b0;
                    run     <= '0;
                end else if (raw_ok == filt_ok) begin
                    run <= '0;
                end else if (run == LAST) begin
                    filt_ok <= raw_ok;
                    run     <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter int unsigned RELEASE_CYCLES    = 50_000_000,
    parameter int unsigned AUX_FILTER_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic wdt_expire,
    input  logic mr_pin_n,
    input  logic aux_ok,
    output logic rst_hi_en,
    output logic rst_lo_pull,
    output logic wr_inhibit,
    output logic aux_low_pull
);
    seq_view_t view;
    cause_t    cause;
    logic      timer_done;
    logic      aux_filt_ok;
    logic      counting;

    assign counting = (view.st == ST_COUNT);

    // Own pull is masked so the pin only counts when the block leaves it free.
    assign rst_lo_pull = ~supply_ok | counting
                       | ((view.st == ST_HOLD) & ~view.by_pin);

    assign cause.supply_low = ~supply_ok;
    assign cause.wdt        = wdt_expire;
    assign cause.manual     = ~mr_pin_n & ~rst_lo_pull;

    assign rst_hi_en  = (view.st != ST_RUN) | ~supply_ok;
    assign wr_inhibit = rst_hi_en;

    supv_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .cause      (cause),
        .timer_done (timer_done),
        .view       (view)
    );

    supv_release_timer #(.DELAY(RELEASE_CYCLES)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (~counting),
        .enable (counting),
        .done   (timer_done)
    );

    supv_aux_filter #(.FILT(AUX_FILTER_CYCLES)) i_aux (
        .clk     (clk),
        .rst     (rst),
        .raw_ok  (aux_ok),
        .filt_ok (aux_filt_ok)
    );

    assign aux_low_pull = ~aux_filt_ok;
endmodule

// File: rtl/supv_reset_ctrl_chk.sv
module supv_reset_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic wdt_expire,
    input logic mr_pin_n,
    input logic aux_ok,
    input logic rst_hi_en,
    input logic rst_lo_pull,
    input logic wr_inhibit,
    input logic aux_low_pull
);
    a_r2_supply_low_resets: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> (rst_hi_en && rst_lo_pull && wr_inhibit));

    a_r5_pull_inside_reset: assert property (@(posedge clk) disable iff (rst)
        rst_lo_pull |-> rst_hi_en);

    a_r7_watchdog_resets: assert property (@(posedge clk) disable iff (rst)
        wdt_expire |=> rst_hi_en);

    a_r6_free_pin_low_resets: assert property (@(posedge clk) disable iff (rst)
        (!mr_pin_n && !rst_lo_pull) |=> rst_hi_en);

    a_r3_release_on_clean_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_hi_en) |-> ($past(supply_ok) && !$past(wdt_expire)));

    a_r9_aux_flip_matches_input: assert property (@(posedge clk) disable iff (rst)
        !$stable(aux_low_pull) |-> (aux_low_pull == !$past(aux_ok)));
endmodule

bind supv_reset_ctrl supv_reset_ctrl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .supply_ok    (supply_ok),
    .wdt_expire   (wdt_expire),
    .mr_pin_n     (mr_pin_n),
    .aux_ok       (aux_ok),
    .rst_hi_en    (rst_hi_en),
    .rst_lo_pull  (rst_lo_pull),
    .wr_inhibit   (wr_inhibit),
    .aux_low_pull (aux_low_pull)
);

// File: tb/test_supv_reset_ctrl.sv
`timescale 1ns/1ps
module test_supv_reset_ctrl;
    localparam int D = 12;
    localparam int F = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup = 1'b1;
    logic wdt = 1'b0;
    logic ext_press = 1'b0;
    logic aux = 1'b1;
    logic pin_n;
    logic hi, lo, inh, auxl;

    int checks = 0;
    int fails = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    // Pin is wired-AND of the block's pull and the external button.
    assign pin_n = !(lo || ext_press);

    supv_reset_ctrl #(.RELEASE_CYCLES(D), .AUX_FILTER_CYCLES(F)) i_supv_reset_ctrl (
        .clk(clk), .rst(rst), .supply_ok(sup), .wdt_expire(wdt), .mr_pin_n(pin_n),
        .aux_ok(aux), .rst_hi_en(hi), .rst_lo_pull(lo), .wr_inhibit(inh),
        .aux_low_pull(auxl)
    );

    // Reference: edges since the last cause, plus a sample history.
    int   quiet = 1;
    bit   pin_started = 1'b0;
    bit   aux_good = 1'b0;
    bit   aux_hist[$];

    function automatic bit m_pull();
        return !sup || (quiet == 0 && !pin_started) || (quiet >= 1 && quiet <= D);
    endfunction

    function automatic bit m_active();
        return (quiet <= D + 1) || !sup;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            quiet = 1;
            pin_started = 1'b0;
            aux_good = 1'b0;
            aux_hist.delete();
        end else begin
            bit man;
            bit all_opp;
            man = ext_press && !m_pull();
            if (!sup || wdt || man) begin
                pin_started = sup && !wdt;
                quiet = 0;
            end else if (quiet < D + 2) begin
                quiet++;
            end
            aux_hist.push_back(aux);
            if (aux_hist.size() > F) void'(aux_hist.pop_front());
            all_opp = (aux_hist.size() == F);
            foreach (aux_hist[k]) if (aux_hist[k] == aux_good) all_opp = 1'b0;
            if (all_opp) aux_good = !aux_good;
        end
    end

    task automatic cmp(string req, string name, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", req, name, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            cmp(phase, "rst_hi_en", hi, m_active());
            cmp("R5", "rst_lo_pull", lo, m_pull());
            cmp("R8", "wr_inhibit", inh, m_active());
            cmp(phase == "R1" ? "R10" : "R9", "aux_low_pull", auxl, !aux_good);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: power-up delay and reset state (R10 for the aux flag)
        step(4);
        rst = 1'b0;
        step(D + 6);
        // R2: supply low for several cycles
        phase = "R2";
        sup = 1'b0; step(3); sup = 1'b1; step(D + 6);
        // R3: single-cycle dip, exact release timing
        phase = "R3";
        sup = 1'b0; step(1); sup = 1'b1; step(D + 6);
        // R4: dips during the release delay restart it
        phase = "R4";
        sup = 1'b0; step(1); sup = 1'b1; step(D / 2);
        sup = 1'b0; step(1); sup = 1'b1; step(D - 1);
        sup = 1'b0; step(1); sup = 1'b1; step(D + 6);
        // R7: watchdog pulses, one inside the delay
        phase = "R7";
        wdt = 1'b1; step(1); wdt = 1'b0; step(5);
        wdt = 1'b1; step(1); wdt = 1'b0; step(D + 6);
        // R6: manual press, release, and press held across the probe cycle
        phase = "R6";
        ext_press = 1'b1; step(5); ext_press = 1'b0; step(D + 6);
        ext_press = 1'b1; step(3); ext_press = 1'b0; step(4);
        ext_press = 1'b1; step(D + 4); ext_press = 1'b0; step(D + 6);
        // R2: supply drop during a pin-started hold takes over the pull
        phase = "R2";
        ext_press = 1'b1; step(3); sup = 1'b0; step(2); sup = 1'b1; step(2);
        ext_press = 1'b0; step(D + 6);
        // R9: aux pulses shorter and longer than the filter
        phase = "R9";
        aux = 1'b0; step(2); aux = 1'b1; step(3);
        aux = 1'b0; step(F + 3); aux = 1'b1; step(F - 1);
        aux = 1'b0; step(1); aux = 1'b1; step(F + 3);
        finish_run();
    end
endmodule